// File: doc/BRIEF.md
# Disk Interface PIO Cycle Timer

This block is the host-side timing engine for a single 16-bit programmed-I/O transfer on a parallel disk interface. A caller pulses `start` with a register address, a read/write select and (for writes) the data word. The block then presents the address. After the address setup time it asserts the read or write strobe (both active low) and holds the strobe for the mode's minimum active time. It then releases the strobe and keeps the address and write data in place for a recovery interval before it pulses `done`. On a read, the captured word is returned on `rdata` together with `done`.

The transfer mode (0 to 4) and an optional cycle time reported by the drive are loaded through a small configuration write port. Every interval is counted in clock cycles, converted from nanosecond limits for a clock period given as a parameter. The recovery interval is lengthened whenever the minimum active and recovery times together fall short of the mode's minimum total cycle time. The drive's IORDY wait line can extend the strobe. If the drive holds the strobe for longer than the allowed wait, the block ends the transfer and flags an error.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset both strobes are high (negated), `busy`, `done`, `dd_oe` and `wait_err` are 0, and transfers use mode 0 timing until a valid mode is written.
- R2: The address appears on `da_o` in the cycle after `start` is accepted. The strobe asserts S = ceil(setup_ns/Tclk) cycles after that edge, where setup_ns is 70, 50, 30, 30 and 25 for modes 0 to 4. `da_o` then stays constant until `done`.
- R3: With IORDY high, the strobe stays low for A = max(ceil(active_ns/Tclk), ceil(write_setup_ns/Tclk), ceil(35/Tclk)) cycles. Here active_ns is 165, 125, 100, 80 and 70 for modes 0 to 4, and write_setup_ns is 60, 45, 30, 30 and 20.
- R4: After the strobe negates, `busy` stays high for R cycles, then `done` goes high. Rmin is the largest of ceil(recovery_ns), ceil(write_hold_ns) and ceil(addr_hold_ns) in cycles, with recovery_ns (0, 0, 0, 70, 25), write_hold_ns (30, 20, 15, 10, 10) and addr_hold_ns (20, 15, 10, 10, 10) for modes 0 to 4. R is Rmin, raised to C - A when A + Rmin is less than C. C is the cycle time in cycles, with table cycle times 600, 383, 240, 180 and 120 ns.
- R5: In modes 3 and 4, a drive-reported cycle time larger than the table value replaces it in C. In modes 0 to 2, and whenever it is not larger, the reported value has no effect.
- R6: IORDY is sampled from the ceil(35/Tclk)-th edge after the strobe asserts. While IORDY is low at a sampling edge, the strobe stays asserted. It negates at the first edge that finds IORDY high once A cycles have elapsed.
- R7: If IORDY has been low at ceil(1250/Tclk) sampling edges in one transfer, the strobe negates at that edge. `wait_err` is then 1 when `done` pulses.
- R8: A read drives `rd_stb_n`, and a write drives `wr_stb_n`. `rdata` holds the `dd_in` value present at the edge where the read strobe negates. During a write, `dd_oe` is 1 and `dd_out` equals the write data from the start edge until `done`. `dd_oe` is 0 during reads and when idle.
- R9: A configuration write with `mode_in` of 0 to 4 (binary) sets the mode and reported cycle time for later transfers. Values 5 to 7 are ignored. A write during a transfer does not change that transfer's timing.
- R10: A `start` pulse while `busy` is 1 is ignored and does not add a transfer.
- R11: `done` is a single-cycle pulse. `wait_err` clears when the next transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr_in | input | ADDR_W | Register address for the transfer |
| wdata_in | input | DATA_W | Write data |
| mode_wr | input | 1 | Load mode and reported cycle time |
| mode_in | input | 3 | Transfer mode, binary 0 to 4 |
| cyc_ns_in | input | 16 | Drive-reported minimum cycle time in ns |
| iordy | input | 1 | Drive ready; low requests wait states |
| dd_in | input | DATA_W | Data bus input from the drive |
| da_o | output | ADDR_W | Address lines |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| dd_out | output | DATA_W | Data bus output value |
| dd_oe | output | 1 | Data bus output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | DATA_W | Captured read data |
| wait_err | output | 1 | IORDY wait exceeded its limit |

## Verification
Each result has a fixed due cycle after the `start` edge. The strobe asserts S cycles later and stays low for A cycles, or longer when IORDY is held low. `done` follows R cycles after negation, so it is seen at the sample point S + A + R cycles after start. The monitor samples on falling clock edges and counts setup, strobe and recovery cycles separately from the `busy` and strobe outputs. When `done` appears it compares those three counts, the captured data and the error flag against the entry the driver queued. The driver changes `dd_in` one sample after the strobe negates and releases IORDY a chosen number of samples after assertion. A capture or release taken one cycle off therefore shows up as a miscompare.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

    localparam int NUM_MODES       = 5;
    localparam int MODE_W          = 3;
    localparam int CNT_W           = 16;
    localparam int IORDY_SAMPLE_NS = 35;
    localparam int IORDY_MAX_NS    = 1250;
    localparam int FIRST_REP_MODE  = 3;

    typedef logic [MODE_W-1:0] mode_t;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } phase_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_RECOV  = 2'd3
    } pio_state_e;

    function automatic int ns_to_cyc(int ns, int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cycle_min_ns(int m);
        case (m)
            0:       return 600;
            1:       return 383;
            2:       return 240;
            3:       return 180;
            default: return 120;
        endcase
    endfunction

    function automatic int addr_setup_ns(int m);
        case (m)
            0:       return 70;
            1:       return 50;
            2:       return 30;
            3:       return 30;
            default: return 25;
        endcase
    endfunction

    function automatic int strobe_min_ns(int m);
        case (m)
            0:       return 165;
            1:       return 125;
            2:       return 100;
            3:       return 80;
            default: return 70;
        endcase
    endfunction

    function automatic int recov_min_ns(int m);
        case (m)
            3:       return 70;
            4:       return 25;
            default: return 0;
        endcase
    endfunction

    function automatic int wdata_setup_ns(int m);
        case (m)
            0:       return 60;
            1:       return 45;
            2:       return 30;
            3:       return 30;
            default: return 20;
        endcase
    endfunction

    function automatic int wdata_hold_ns(int m);
        case (m)
            0:       return 30;
            1:       return 20;
            2:       return 15;
            default: return 10;
        endcase
    endfunction

    function automatic int addr_hold_ns(int m);
        case (m)
            0:       return 20;
            1:       return 15;
            default: return 10;
        endcase
    endfunction

    // Turn the nanosecond limits of one mode into cycle counts; any shortfall
    // against the total cycle time is added to the recovery phase.
    function automatic phase_t derive_phase(int m, int rep_ns, int per);
        int s;
        int a;
        int rmin;
        int cyc;
        int c;
        int r;
        phase_t p;
        s    = imax(ns_to_cyc(addr_setup_ns(m), per), 1);
        a    = imax(ns_to_cyc(strobe_min_ns(m), per), ns_to_cyc(wdata_setup_ns(m), per));
        a    = imax(a, ns_to_cyc(IORDY_SAMPLE_NS, per));
        rmin = imax(ns_to_cyc(recov_min_ns(m), per),
                    imax(ns_to_cyc(wdata_hold_ns(m), per), ns_to_cyc(addr_hold_ns(m), per)));
        rmin = imax(rmin, 1);
        cyc  = cycle_min_ns(m);
        if (m >= FIRST_REP_MODE && rep_ns > cyc) begin
            cyc = rep_ns;
        end
        c = ns_to_cyc(cyc, per);
        r = (a + rmin >= c) ? rmin : c - a;
        p.setup  = CNT_W'(s);
        p.active = CNT_W'(a);
        p.recov  = CNT_W'(r);
        return p;
    endfunction

endpackage

// File: rtl/pio_mode_cfg.sv
module pio_mode_cfg
    import pio_timer_pkg::*;
#(
    parameter int CLK_NS = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_wr,
    input  mode_t       mode_in,
    input  logic [15:0] rep_ns,
    output phase_t      phase_q
);

    localparam phase_t RESET_PHASE = derive_phase(0, 0, CLK_NS);
    localparam mode_t  MODE_LIMIT  = MODE_W'(NUM_MODES);

    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            phase_q <= RESET_PHASE;
        end else if (mode_wr && (mode_in < MODE_LIMIT)) begin
            mode_q  <= mode_in;
            phase_q <= derive_phase(int'(mode_in), int'(rep_ns), CLK_NS);
        end
    end

    // R9: only legal modes are ever held
    a_r9_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode_q < MODE_LIMIT);

    // R4: stored active plus recovery never undercuts the table cycle time
    a_r4_cycle_floor: assert property (@(posedge clk) disable iff (rst)
        (int'(phase_q.active) + int'(phase_q.recov)) * CLK_NS >= cycle_min_ns(int'(mode_q)));

endmodule

// File: rtl/pio_iordy_watch.sv
module pio_iordy_watch #(
    parameter int WAIT_CYC = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic in_active,
    input  logic armed,
    input  logic iordy,
    output logic timeout
);

    localparam int WW = $clog2(WAIT_CYC + 1);
    localparam logic [WW-1:0] LAST = WW'(WAIT_CYC - 1);

    logic [WW-1:0] wcnt;

    assign timeout = armed && !iordy && (wcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !in_active) begin
            wcnt <= '0;
        end else if (armed && !iordy && !timeout) begin
            wcnt <= wcnt + WW'(1);
        end
    end

    // R7: the wait counter never runs past its limit
    a_r7_wait_bound: assert property (@(posedge clk) disable iff (rst)
        wcnt <= LAST);

    // R7: outside a strobe the counter is back at zero
    a_r7_wait_cleared: assert property (@(posedge clk) disable iff (rst)
        !in_active |=> (wcnt == '0) || in_active);

endmodule

// File: rtl/pio_phase_ctrl.sv
module pio_phase_ctrl
    import pio_timer_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int TA_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  phase_t            phase_in,
    input  logic              iordy,
    input  logic [DATA_W-1:0] dd_in,
    input  logic              timeout,
    output logic              in_active,
    output logic              armed,
    output logic [ADDR_W-1:0] da_o,
    output logic              rd_stb_n,
    output logic              wr_stb_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              wait_err
);

    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] TA_M1 = CNT_W'(TA_CYC - 1);

    pio_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_inc;
    phase_t            ph;
    logic              is_wr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              min_met;

    assign cnt_inc   = cnt + ONE;
    assign min_met   = cnt_inc >= ph.active;
    assign busy      = (state != ST_IDLE);
    assign in_active = (state == ST_ACTIVE);
    assign armed     = in_active && (cnt >= TA_M1);
    assign rd_stb_n  = !(in_active && !is_wr);
    assign wr_stb_n  = !(in_active && is_wr);
    assign dd_oe     = busy && is_wr;
    assign dd_out    = wdata_q;
    assign da_o      = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            ph       <= '0;
            is_wr    <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata    <= '0;
            done     <= 1'b0;
            wait_err <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ph       <= phase_in;
                        is_wr    <= wr_en;
                        addr_q   <= addr_in;
                        wdata_q  <= wdata_in;
                        wait_err <= 1'b0;
                        cnt      <= '0;
                        state    <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt_inc == ph.setup) begin
                        cnt   <= '0;
                        state <= ST_ACTIVE;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                ST_ACTIVE: begin
                    if (timeout || (min_met && iordy)) begin
                        wait_err <= timeout;
                        if (!is_wr) begin
                            rdata <= dd_in;
                        end
                        cnt   <= '0;
                        state <= ST_RECOV;
                    end else if (!min_met) begin
                        cnt <= cnt_inc;
                    end
                end
                ST_RECOV: begin
                    if (cnt_inc == ph.recov) begin
                        cnt   <= '0;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: address lines hold still for the whole transfer
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(da_o));

    // R6: a low IORDY at a sampling edge keeps the strobe asserted
    a_r6_iordy_hold: assert property (@(posedge clk) disable iff (rst)
        (armed && !iordy && !timeout) |=> in_active);

    // R8: read data equals the bus value at the negation edge
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_ACTIVE && state == ST_RECOV && !is_wr) |-> rdata == $past(dd_in));

    // R10: a start while busy leaves the running transfer untouched
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && busy && state != ST_RECOV) |=> busy && $stable(da_o));

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
    import pio_timer_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              mode_wr,
    input  logic [2:0]        mode_in,
    input  logic [15:0]       cyc_ns_in,
    input  logic              iordy,
    input  logic [DATA_W-1:0] dd_in,
    output logic [ADDR_W-1:0] da_o,
    output logic              rd_stb_n,
    output logic              wr_stb_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              wait_err
);

    localparam int TA_CYC   = ns_to_cyc(IORDY_SAMPLE_NS, CLK_NS);
    localparam int WAIT_CYC = ns_to_cyc(IORDY_MAX_NS, CLK_NS);

    phase_t phase_cfg;
    logic   in_active;
    logic   armed;
    logic   timeout;

    pio_mode_cfg #(
        .CLK_NS (CLK_NS)
    ) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .mode_wr (mode_wr),
        .mode_in (mode_in),
        .rep_ns  (cyc_ns_in),
        .phase_q (phase_cfg)
    );

    pio_iordy_watch #(
        .WAIT_CYC (WAIT_CYC)
    ) watch_i (
        .clk       (clk),
        .rst       (rst),
        .in_active (in_active),
        .armed     (armed),
        .iordy     (iordy),
        .timeout   (timeout)
    );

    pio_phase_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TA_CYC (TA_CYC)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wr_en     (wr_en),
        .addr_in   (addr_in),
        .wdata_in  (wdata_in),
        .phase_in  (phase_cfg),
        .iordy     (iordy),
        .dd_in     (dd_in),
        .timeout   (timeout),
        .in_active (in_active),
        .armed     (armed),
        .da_o      (da_o),
        .rd_stb_n  (rd_stb_n),
        .wr_stb_n  (wr_stb_n),
        .dd_out    (dd_out),
        .dd_oe     (dd_oe),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .wait_err  (wait_err)
    );

    // R8: never both strobes at once
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_stb_n || wr_stb_n);

endmodule

// File: tb/pio_cycle_timer_tb_top.sv
module pio_cycle_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr_in = '0;
    logic [15:0] wdata_in = '0;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_in = '0;
    logic [15:0] cyc_ns_in = '0;
    logic        iordy = 1'b1;
    logic [15:0] dd_in = '0;
    logic [2:0]  da_o;
    logic        rd_stb_n, wr_stb_n, dd_oe, busy, done, wait_err;
    logic [15:0] dd_out, rdata;

    always #5 clk = ~clk;

    pio_cycle_timer dut_i (
        .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .addr_in(addr_in),
        .wdata_in(wdata_in), .mode_wr(mode_wr), .mode_in(mode_in), .cyc_ns_in(cyc_ns_in),
        .iordy(iordy), .dd_in(dd_in), .da_o(da_o), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n),
        .dd_out(dd_out), .dd_oe(dd_oe), .busy(busy), .done(done), .rdata(rdata),
        .wait_err(wait_err)
    );

    typedef struct {
        int          s;
        int          a;
        int          r;
        bit          wr;
        logic [2:0]  addr;
        logic [15:0] data;
        bit          err;
    } exp_t;

    exp_t q[$];
    int nvec = 0;
    int nfail = 0;
    int md = 0;
    int rp = 0;

    int t_cyc[5] = '{600, 383, 240, 180, 120};
    int t_su[5]  = '{70, 50, 30, 30, 25};
    int t_act[5] = '{165, 125, 100, 80, 70};
    int t_rec[5] = '{0, 0, 0, 70, 25};
    int t_wsu[5] = '{60, 45, 30, 30, 20};
    int t_wh[5]  = '{30, 20, 15, 10, 10};
    int t_ah[5]  = '{20, 15, 10, 10, 10};

    function automatic int cy(int ns);
        return (ns + 9) / 10;
    endfunction

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int TO_A = 3 + 125;  // strobe cycles when the wait limit hits

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input int m, input int rep);
        @(negedge clk);
        mode_wr = 1'b1; mode_in = 3'(m); cyc_ns_in = 16'(rep);
        @(negedge clk);
        mode_wr = 1'b0;
        if (m < 5) begin md = m; rp = rep; end
    endtask

    // rel: 0 = IORDY always high, >0 = release at that strobe sample, -1 = never
    task automatic xfer(input bit wr, input logic [2:0] a, input logic [15:0] d,
                        input int rel, input bit poke);
        exp_t e;
        int rmin, c, cyc_ns;
        e.s  = cy(t_su[md]);
        e.a  = mx(mx(cy(t_act[md]), cy(t_wsu[md])), cy(35));
        rmin = mx(cy(t_rec[md]), mx(cy(t_wh[md]), cy(t_ah[md])));
        cyc_ns = (md >= 3 && rp > t_cyc[md]) ? rp : t_cyc[md];
        c    = cy(cyc_ns);
        e.r  = (e.a + rmin >= c) ? rmin : c - e.a;
        e.wr = wr; e.addr = a; e.data = d; e.err = 1'b0;
        if (rel < 0) begin e.a = TO_A; e.err = 1'b1; end
        else if (rel > 0) e.a = mx(e.a, rel);
        q.push_back(e);
        @(negedge clk);
        start = 1'b1; wr_en = wr; addr_in = a; wdata_in = d; dd_in = d; iordy = (rel == 0);
        @(negedge clk);
        start = 1'b0;
        while (rd_stb_n && wr_stb_n) @(negedge clk);
        if (poke) begin
            start = 1'b1; addr_in = ~a; mode_wr = 1'b1; mode_in = 3'd0; cyc_ns_in = '0;
            @(negedge clk);
            start = 1'b0; mode_wr = 1'b0; md = 0; rp = 0;
        end
        if (rel > 0) begin
            repeat (rel - 1) @(negedge clk);
            iordy = 1'b1;
        end
        while (!(rd_stb_n && wr_stb_n)) @(negedge clk);
        dd_in = ~d;
        while (!done) @(negedge clk);
        iordy = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: counts phases, pops the expected entry at done and compares
    int  s_cnt = 0, a_cnt = 0, r_cnt = 0;
    bit  seen = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10 transfer without a queued start", 1, 0);
                end else if (!(rd_stb_n && wr_stb_n)) begin
                    a_cnt++;
                    seen = 1'b1;
                    if (a_cnt == 1) begin
                        check(da_o == q[0].addr, "R2 address at strobe", int'(da_o), int'(q[0].addr));
                        check(wr_stb_n == !q[0].wr && rd_stb_n == q[0].wr, "R8 strobe select",
                              int'(wr_stb_n), int'(!q[0].wr));
                        check(dd_oe == q[0].wr, "R8 output enable", int'(dd_oe), int'(q[0].wr));
                        if (q[0].wr) check(dd_out == q[0].data, "R8 write data", int'(dd_out), int'(q[0].data));
                    end
                end else if (!seen) s_cnt++;
                else r_cnt++;
            end
            if (done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10 done without a queued start", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(s_cnt == e.s, "R2 setup cycles", s_cnt, e.s);
                    check(a_cnt == e.a, "R3/R6/R7 strobe cycles", a_cnt, e.a);
                    check(r_cnt == e.r, "R4/R5 recovery cycles", r_cnt, e.r);
                    check(wait_err == e.err, "R7/R11 wait error", int'(wait_err), int'(e.err));
                    check(da_o == e.addr, "R2 address held to done", int'(da_o), int'(e.addr));
                    check(dd_oe == 1'b0, "R8 enable off at done", int'(dd_oe), 0);
                    if (!e.wr) check(rdata == e.data, "R8 read capture", int'(rdata), int'(e.data));
                end
                s_cnt = 0; a_cnt = 0; r_cnt = 0; seen = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && done) begin
            @(negedge clk);
            check(done == 1'b0, "R11 done single pulse", int'(done), 0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nvec++; nfail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rd_stb_n && wr_stb_n, "R1 strobes negated", int'({rd_stb_n, wr_stb_n}), 3);
        check(!busy && !done, "R1 idle", int'({busy, done}), 0);
        check(!dd_oe && !wait_err, "R1 enable and error clear", int'({dd_oe, wait_err}), 0);

        xfer(1'b0, 3'd3, 16'hA5C3, 0, 1'b0);   // R1 default mode 0 read
        xfer(1'b1, 3'd5, 16'h1234, 0, 1'b0);   // mode 0 write
        set_mode(1, 0);
        xfer(1'b1, 3'd6, 16'h0F0F, 0, 1'b0);   // R4 stretched recovery
        set_mode(2, 500);
        xfer(1'b0, 3'd1, 16'h5A5A, 0, 1'b0);   // R5 reported value ignored below mode 3
        set_mode(3, 0);
        xfer(1'b0, 3'd2, 16'hBEEF, 0, 1'b0);
        set_mode(3, 250);
        xfer(1'b1, 3'd7, 16'hCAFE, 0, 1'b0);   // R5 reported cycle lengthens recovery
        set_mode(3, 100);
        xfer(1'b0, 3'd4, 16'h8001, 0, 1'b0);   // R5 smaller reported value ignored
        set_mode(4, 200);
        xfer(1'b0, 3'd0, 16'h7FFE, 0, 1'b0);
        set_mode(4, 0);
        xfer(1'b1, 3'd3, 16'h4321, 0, 1'b0);
        set_mode(7, 0);                         // R9 illegal mode ignored
        xfer(1'b0, 3'd5, 16'h1357, 0, 1'b0);
        xfer(1'b0, 3'd6, 16'h2468, 30, 1'b0);  // R6 wait states stretch strobe
        xfer(1'b0, 3'd1, 16'h9999, 3, 1'b0);   // R6 early release before sample
        xfer(1'b0, 3'd2, 16'hF00D, -1, 1'b0);  // R7 wait limit exceeded
        xfer(1'b1, 3'd4, 16'h0101, 0, 1'b0);   // R11 error cleared by next start
        xfer(1'b0, 3'd7, 16'h6C6C, 0, 1'b1);   // R10 start ignored, R9 mode write mid transfer
        xfer(1'b0, 3'd0, 16'h3C3C, 0, 1'b0);   // R9 mode 0 now in force
        xfer(1'b0, 3'd3, 16'hABCD, 128, 1'b0); // R7 release at the last allowed edge
        repeat (5) @(negedge clk);
        check(q.size() == 0, "R10 all queued transfers done", q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule